// File: doc/BRIEF.md
# Programmable Step Delay with Cascade Override

This block is a clocked model of a programmable delay element. A single-bit data input is carried through a shift register and read back from a selectable tap. The delay is a fixed minimum latency plus a step count, where one step is one clock cycle. The delay can never be shorter than that minimum.

The step count comes from an 11-bit control word that passes through a transparent holding stage. Bits 9:0 form the unsigned step code. Bit 10 is kept for chaining several delay blocks and is presented on its own output. Two override pins force the delay to its minimum or to one step past the largest code. They leave the held word untouched. An active-low enable replaces the data input with logic low before the shift register, so a disabled input still travels through the full delay.

Top module: `prog_delay_line`

## Requirements
- R1: A synchronous reset drives `dout` low (the shift register is cleared) and clears the held control word. After reset, with `ctl_hold` high, `cascade_ctl` reads 0 whatever `ctl_word` carries.
- R2: While `ctl_hold` is low the holding stage is transparent. `ctl_word` sets the delay directly and `ctl_word[10]` appears on `cascade_ctl`.
- R3: While `ctl_hold` is high, the word present when `ctl_hold` rose is kept, and later changes on `ctl_word` (including bit 10) have no effect.
- R4: With both override pins low, a one-cycle pulse on `din` first appears on `dout` MIN_LAT + code cycles later. The code is the unsigned value of `ctl_word[9:0]`, with bit 0 the least significant. With MIN_LAT = 2, code 0 gives 2 cycles, code 5 gives 7 cycles and code 1023 gives 1025 cycles.
- R5: With `set_min` high and `set_max` low, the delay is MIN_LAT whatever the held code is.
- R6: With `set_max` high and `set_min` low, the delay is MIN_LAT + 1024 cycles, one step past the largest code.
- R7: With both override pins high, `cfg_err` is high and the delay falls back to MIN_LAT. `cfg_err` is low whenever at most one override pin is high.
- R8: While `en_n` is high, logic low enters the delay path in place of `din`. A pulse driven while disabled never reaches `dout`.
- R9: The enable acts at the input of the delay path. A sample taken while `en_n` was low still reaches `dout` after the full delay, even if `en_n` goes high in the meantime.
- R10: Releasing an override restores the delay of the held word. The overrides do not change the stored word.
- R11: A change of the step count takes effect on the clock edge after it appears. Samples already in the shift register are kept and are read from the new tap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| din | input | 1 | Data input to be delayed |
| en_n | input | 1 | Active-low input enable; high substitutes logic low |
| ctl_word | input | 11 | Control word: [9:0] step code, [10] cascade bit |
| ctl_hold | input | 1 | Low: holding stage transparent; high: hold the word |
| set_min | input | 1 | Force the minimum delay |
| set_max | input | 1 | Force the minimum delay plus 1024 steps |
| dout | output | 1 | Delayed data output |
| cascade_ctl | output | 1 | Held cascade bit (word bit 10) |
| cfg_err | output | 1 | Both override pins high |

## Verification
The hardest situation to reach from the ports is a step-count change while a sample is still inside the shift register. The bench launches a single pulse at one code and changes the transparent word a few cycles later. It then expects the pulse at the cycle where its age matches the new tap, which shows both the one-edge update and that the stored samples were kept. The longest delays also need care. Before each measurement the bench drives 1030 cycles of low input, so that an earlier pulse cannot show up at a deep tap. The maximum override is then timed over more than a thousand cycles.

// File: rtl/pdl_pkg.sv
package pdl_pkg;
   typedef enum logic [1:0] {
      OVR_NONE = 2'b00,
      OVR_MAX  = 2'b01,
      OVR_MIN  = 2'b10,
      OVR_BAD  = 2'b11
   } ovr_t;
endpackage

// File: rtl/pdl_ctrl_latch.sv
module pdl_ctrl_latch #(
   parameter int WORD_W = 11
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              hold,
   input  logic [WORD_W-1:0] word_in,
   output logic [WORD_W-1:0] word_out
);
   if (WORD_W < 2) begin : g_bad_width
      $error("pdl_ctrl_latch: WORD_W must be at least 2");
   end

   logic [WORD_W-1:0] stored;

   always_ff @(posedge clk) begin
      if (rst)
         stored <= '0;
      else if (!hold)
         stored <= word_in;
   end

   // transparent while hold is low, frozen copy while high
   assign word_out = hold ? stored : word_in;
endmodule

// File: rtl/pdl_step_select.sv
module pdl_step_select
   import pdl_pkg::*;
#(
   parameter int CODE_W = 10,
   localparam int STEP_W = CODE_W + 1
) (
   input  logic [CODE_W-1:0] code,
   input  logic              set_min,
   input  logic              set_max,
   output logic [STEP_W-1:0] steps,
   output logic              cfg_err
);
   localparam logic [STEP_W-1:0] TOP_STEP = STEP_W'(1) << CODE_W;

   ovr_t ovr;

   assign ovr = ovr_t'({set_min, set_max});

   always_comb begin
      cfg_err = 1'b0;
      unique case (ovr)
         OVR_NONE: steps = {1'b0, code};
         OVR_MAX:  steps = TOP_STEP;
         OVR_MIN:  steps = '0;
         default: begin
            steps   = '0;
            cfg_err = 1'b1;
         end
      endcase
   end
endmodule

// File: rtl/pdl_tap_line.sv
module pdl_tap_line #(
   parameter int  MIN_LAT   = 2,
   parameter int  STEP_W    = 11,
   parameter int  MAX_STEPS = 1024,
   parameter bit  REG_SEL   = 1'b1,
   localparam int DEPTH     = MIN_LAT + MAX_STEPS,
   localparam int IDX_W     = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              din,
   input  logic [STEP_W-1:0] steps,
   output logic              dout
);
   if (MIN_LAT < 1) begin : g_bad_lat
      $error("pdl_tap_line: MIN_LAT must be at least 1");
   end
   if (MAX_STEPS < 1) begin : g_bad_steps
      $error("pdl_tap_line: MAX_STEPS must be at least 1");
   end

   logic [DEPTH-1:0]  chain;
   logic [STEP_W-1:0] sel;
   logic [IDX_W-1:0]  idx;

   always_ff @(posedge clk) begin
      if (rst)
         chain <= '0;
      else
         chain <= {chain[DEPTH-2:0], din};
   end

   if (REG_SEL) begin : g_reg_sel
      // step count is applied from the next edge
      always_ff @(posedge clk) begin
         if (rst)
            sel <= '0;
         else
            sel <= steps;
      end
   end else begin : g_comb_sel
      assign sel = steps;
   end

   assign idx  = IDX_W'(MIN_LAT - 1) + IDX_W'(sel);
   assign dout = chain[idx];
endmodule

// File: rtl/prog_delay_line.sv
module prog_delay_line #(
   parameter int  CODE_W  = 10,
   parameter int  MIN_LAT = 2,
   parameter bit  REG_SEL = 1'b1,
   localparam int WORD_W  = CODE_W + 1,
   localparam int STEP_W  = CODE_W + 1,
   localparam int MAX_STEPS = 1 << CODE_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              din,
   input  logic              en_n,
   input  logic [WORD_W-1:0] ctl_word,
   input  logic              ctl_hold,
   input  logic              set_min,
   input  logic              set_max,
   output logic              dout,
   output logic              cascade_ctl,
   output logic              cfg_err
);
   if (CODE_W < 1 || CODE_W > 12) begin : g_bad_code
      $error("prog_delay_line: CODE_W out of range 1..12");
   end

   logic [WORD_W-1:0] held_word;
   logic [STEP_W-1:0] eff_steps;
   logic              gated_in;

   pdl_ctrl_latch #(.WORD_W(WORD_W)) u_latch (
      .clk      (clk),
      .rst      (rst),
      .hold     (ctl_hold),
      .word_in  (ctl_word),
      .word_out (held_word)
   );

   pdl_step_select #(.CODE_W(CODE_W)) u_select (
      .code    (held_word[CODE_W-1:0]),
      .set_min (set_min),
      .set_max (set_max),
      .steps   (eff_steps),
      .cfg_err (cfg_err)
   );

   // disabled input is replaced by low ahead of the delay path
   assign gated_in = din & ~en_n;

   pdl_tap_line #(
      .MIN_LAT   (MIN_LAT),
      .STEP_W    (STEP_W),
      .MAX_STEPS (MAX_STEPS),
      .REG_SEL   (REG_SEL)
   ) u_line (
      .clk   (clk),
      .rst   (rst),
      .din   (gated_in),
      .steps (eff_steps),
      .dout  (dout)
   );

   assign cascade_ctl = held_word[CODE_W];
endmodule

// File: rtl/pdl_checker.sv
module pdl_checker #(
   parameter int  CODE_W  = 10,
   parameter int  MIN_LAT = 2,
   localparam int DEPTH   = MIN_LAT + (1 << CODE_W),
   localparam int RUN_W   = $clog2(DEPTH + 2)
) (
   input logic              clk,
   input logic              rst,
   input logic              din,
   input logic              en_n,
   input logic [CODE_W:0]   ctl_word,
   input logic              ctl_hold,
   input logic              set_min,
   input logic              set_max,
   input logic              dout,
   input logic              cascade_ctl,
   input logic              cfg_err
);
   logic [MIN_LAT-1:0] hist;
   logic               prev_min;
   logic [RUN_W-1:0]   dis_run;

   always_ff @(posedge clk) begin
      if (rst) begin
         hist     <= '0;
         prev_min <= 1'b0;
         dis_run  <= '0;
      end else begin
         hist[0] <= din & ~en_n;
         for (int k = 1; k < MIN_LAT; k++) hist[k] <= hist[k-1];
         prev_min <= set_min;
         if (!en_n)
            dis_run <= '0;
         else if (dis_run < RUN_W'(DEPTH))
            dis_run <= dis_run + 1'b1;
      end
   end

   assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (dout == 1'b0));

   assert_transparent_R2: assert property (@(posedge clk) disable iff (rst)
      !ctl_hold |-> (cascade_ctl == ctl_word[CODE_W]));

   assert_hold_stable_R3: assert property (@(posedge clk) disable iff (rst)
      (ctl_hold && $past(ctl_hold) && !$past(rst)) |-> $stable(cascade_ctl));

   // set_min (alone, or with set_max per R7) reads the shortest tap
   assert_min_tap_R5: assert property (@(posedge clk) disable iff (rst)
      prev_min |-> (dout == hist[MIN_LAT-1]));

   assert_disabled_low_R8: assert property (@(posedge clk) disable iff (rst)
      (dis_run >= RUN_W'(DEPTH)) |-> !dout);
endmodule

bind prog_delay_line pdl_checker #(.CODE_W(CODE_W), .MIN_LAT(MIN_LAT)) u_pdl_checker (
   .clk         (clk),
   .rst         (rst),
   .din         (din),
   .en_n        (en_n),
   .ctl_word    (ctl_word),
   .ctl_hold    (ctl_hold),
   .set_min     (set_min),
   .set_max     (set_max),
   .dout        (dout),
   .cascade_ctl (cascade_ctl),
   .cfg_err     (cfg_err)
);

// File: tb/test_prog_delay_line.sv
module test_prog_delay_line;
   localparam int MIN_LAT = 2;
   localparam int DEPTH   = MIN_LAT + 1024;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        din = 1'b0;
   logic        en_n = 1'b0;
   logic [10:0] ctl_word = 11'h400;
   logic        ctl_hold = 1'b1;
   logic        set_min = 1'b0;
   logic        set_max = 1'b0;
   logic        dout, cascade_ctl, cfg_err;

   int n_vec = 0;
   int n_bad = 0;

   always #2 clk = ~clk;

   prog_delay_line i_prog_delay_line (
      .clk (clk), .rst (rst), .din (din), .en_n (en_n),
      .ctl_word (ctl_word), .ctl_hold (ctl_hold),
      .set_min (set_min), .set_max (set_max),
      .dout (dout), .cascade_ctl (cascade_ctl), .cfg_err (cfg_err)
   );

   task automatic check(input string req, input int act, input int exp);
      n_vec++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: got %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic flush();
      din = 1'b0;
      repeat (DEPTH + 4) @(negedge clk);
   endtask

   // launch a one-cycle pulse; return cycles until dout first goes high (0 = never)
   task automatic measure(output int cnt, input int limit,
                          input int sw_at, input int sw_code, input bit off_after);
      cnt = 0;
      din = 1'b1;
      for (int c = 1; c <= limit; c++) begin
         @(negedge clk);
         if (c == 1) begin
            din = 1'b0;
            if (off_after) en_n = 1'b1;
         end
         if (dout && cnt == 0) cnt = c;
         if (c == sw_at) ctl_word = 11'(sw_code);
         if (cnt != 0) break;
      end
   endtask

   task automatic t_reset();
      check("R1 dout after reset", int'(dout), 0);
      check("R1 held cascade bit cleared", int'(cascade_ctl), 0);
      check("R7 no error with overrides low", int'(cfg_err), 0);
   endtask

   task automatic t_codes();
      int d;
      ctl_hold = 1'b0;
      ctl_word = 11'd0;   flush(); measure(d, 1100, 0, 0, 0);
      check("R4 code 0 delay", d, 2);
      ctl_word = 11'd5;   flush(); measure(d, 1100, 0, 0, 0);
      check("R4 code 5 delay", d, 7);
      ctl_word = 11'd1023; flush(); measure(d, 1100, 0, 0, 0);
      check("R4 code 1023 delay", d, 1025);
      ctl_word = 11'h400 | 11'd3; @(negedge clk);
      check("R2 transparent cascade bit", int'(cascade_ctl), 1);
      flush(); measure(d, 1100, 0, 0, 0);
      check("R2 transparent code 3 delay", d, 5);
   endtask

   task automatic t_hold_overrides();
      int d;
      ctl_hold = 1'b0; ctl_word = 11'h400 | 11'd5; @(negedge clk);
      ctl_hold = 1'b1; @(negedge clk);
      ctl_word = 11'd700; @(negedge clk);
      check("R3 cascade bit held", int'(cascade_ctl), 1);
      flush(); measure(d, 1100, 0, 0, 0);
      check("R3 held code 5 ignores new word", d, 7);
      set_min = 1'b1; flush(); measure(d, 1100, 0, 0, 0);
      check("R5 set_min delay", d, 2);
      check("R7 no error with set_min only", int'(cfg_err), 0);
      set_min = 1'b0; set_max = 1'b1; flush(); measure(d, 1100, 0, 0, 0);
      check("R6 set_max delay", d, 1026);
      set_min = 1'b1; @(negedge clk);
      check("R7 error flag with both", int'(cfg_err), 1);
      flush(); measure(d, 1100, 0, 0, 0);
      check("R7 fallback delay", d, 2);
      set_min = 1'b0; set_max = 1'b0; @(negedge clk);
      check("R7 error clears", int'(cfg_err), 0);
      flush(); measure(d, 1100, 0, 0, 0);
      check("R10 held word restored after overrides", d, 7);
      check("R10 cascade bit kept", int'(cascade_ctl), 1);
   endtask

   task automatic t_enable();
      int d;
      ctl_hold = 1'b0; ctl_word = 11'd40;
      en_n = 1'b1; flush(); measure(d, 1100, 0, 0, 0);
      check("R8 disabled pulse never arrives", d, 0);
      en_n = 1'b0; flush(); measure(d, 1100, 0, 0, 1);
      check("R9 sample before disable still arrives", d, 42);
      en_n = 1'b0;
   endtask

   task automatic t_code_change();
      int d;
      ctl_hold = 1'b0; ctl_word = 11'd50; flush();
      measure(d, 1100, 5, 20, 0);
      check("R11 pulse kept and read from new tap", d, 22);
   endtask

   initial begin
      #800000;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      t_reset();
      t_codes();
      t_hold_overrides();
      t_enable();
      t_code_change();
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule